// File: doc/BRIEF.md
# Quasi-Sequential Multi-Way Stream Buffer

This block is a prefetch unit that sits next to a small direct-mapped first-level cache. It keeps several independent streams of prefetched lines. Each stream lives in a short FIFO called a way, and each entry holds a line address, a flag that says the line has been requested from memory, a flag that says its data has arrived, and the 128-bit line. Addresses on every port are line addresses, so one line is 16 bytes and consecutive streams step by exactly one line.

When the cache misses, it offers the missing line address. The block compares that address against the oldest three entries of every way. On a match it returns the line. Any older lines ahead of the match are thrown away, and the freed slots are loaded straight away with the next sequential line addresses. If the matched line is still in flight, the block stalls new misses until the data lands. On no match, the block reports a plain miss. The least-recently-used way is then restarted at the line that follows the miss, and the cache fetches the missing line by its own path. Prefetch reads go out one per cycle to a pipelined next-level memory. They carry a tag, so responses can be matched even after the way that asked for them has been reused.

Top module: `sb_stream_buffer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, miss_ready is 1, resp_valid is 0 and mem_req_valid is 0. All ways start empty and inactive.
- R2: A miss that matches no compared entry of any active way is accepted. It is answered in the next cycle with resp_hit=0 and resp_data all zero. The least-recently-used way is cleared, and it then holds the DEPTH line addresses that follow the missing one.
- R3: mem_req_tag carries the way number in its low log2(NUM_WAYS) bits and that way's GEN_W-bit generation above them. Of all entries not yet requested, the lowest-numbered way is offered first, and within it the oldest entry. An offer counts as issued only in a cycle where mem_req_ready is 1; otherwise the same line is offered again.
- R4: A miss that matches an entry whose data has arrived is answered in the next cycle with resp_hit=1 and that line's data. The entry leaves its way, and the freed slot is loaded in the same update with the way's next sequential line address.
- R5: Only the oldest CMP (3) entries of a way are compared. A match in the second or third entry discards the older entries in front of it. An address held only in the fourth entry counts as no match.
- R6: A miss that matches an entry still waiting for memory makes miss_ready 0 from the next cycle on. The hit response (resp_hit=1) appears in the cycle after the memory response that fills the entry, and miss_ready is 1 again in that same cycle.
- R7: Every match and every new stream marks its way most recently used. After reset, new streams take ways 0, 1, 2, 3 in that order.
- R8: Four ways follow four unrelated streams at once. A prefetched line is presented on resp_data only in answer to a miss that asks for it.
- R9: A memory response updates an entry only when its way, generation and line address all agree. A response from an earlier generation of a way is dropped, even if its address equals an entry of the new stream.
- R10: When more than one way matches, the lowest-numbered way supplies the line and the other ways keep their entries.
- R11: Several prefetch reads may be outstanding. At most one response arrives per cycle, at any cycle after its request, and echoes the request's address and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a missing line |
| miss_ready | output | 1 | Block can accept a miss this cycle |
| miss_addr | input | ADDR_W | Line address of the miss |
| resp_valid | output | 1 | Answer to an accepted miss |
| resp_hit | output | 1 | 1: line supplied from a way, 0: not held |
| resp_data | output | DATA_W | Line data on a hit, zero otherwise |
| mem_req_valid | output | 1 | Prefetch read offered |
| mem_req_ready | input | 1 | Memory takes the offered read |
| mem_req_addr | output | ADDR_W | Line address to prefetch |
| mem_req_tag | output | GEN_W+log2(NUM_WAYS) | {generation, way} |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_addr | input | ADDR_W | Echoed line address |
| mem_rsp_tag | input | GEN_W+log2(NUM_WAYS) | Echoed tag |
| mem_rsp_data | input | DATA_W | Returned line |

## Verification
The block is driven with several kinds of miss pattern. A pure ascending walk inside one stream checks head hits. Jumps of one, two and three lines ahead of the head separate a legal skip from the uncompared fourth entry. Four interleaved streams expose LRU replacement order. Two ways built to hold the same lines test the way priority. Long memory latency with rapid reuse of a way sends old-generation data back onto addresses the new stream also holds, which shows whether stale responses are really filtered. Throttled and random mem_req_ready shows whether issue order survives back-pressure. A long random phase of near-sequential misses mixes all of these cases.

// File: rtl/sb_pkg.sv
package sb_pkg;
    // Miss handling mode of the buffer
    typedef enum logic {
        SB_IDLE = 1'b0,
        SB_WAIT = 1'b1
    } sb_mode_e;
endpackage

// File: rtl/sb_pick.sv
// Lowest-index-first selector over a request vector
module sb_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/sb_lru.sv
// Rank-based recency tracker: rank 0 is most recent, NUM_WAYS-1 is the victim
module sb_lru #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);
    logic [NUM_WAYS-1:0][WAY_W-1:0] rank_q, rank_d;

    always_comb begin
        rank_d = rank_q;
        if (touch) begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                if (rank_q[i] < rank_q[touch_way]) rank_d[i] = rank_q[i] + 1'b1;
            end
            rank_d[touch_way] = '0;
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (rank_q[i] == WAY_W'(NUM_WAYS - 1)) victim = WAY_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WAYS; i++) rank_q[i] <= WAY_W'(NUM_WAYS - 1 - i);
        end else begin
            rank_q <= rank_d;
        end
    end
endmodule

// File: rtl/sb_match.sv
// Compares a key against the leading CMP entries of every way
module sb_match #(
    parameter int NUM_WAYS = 4,
    parameter int CMP      = 3,
    parameter int ADDR_W   = 28,
    parameter int WAY_W    = 2,
    parameter int SLOT_W   = 2
) (
    input  logic [ADDR_W-1:0]                          key,
    input  logic [NUM_WAYS-1:0][CMP-1:0]               cmp_vld,
    input  logic [NUM_WAYS-1:0][CMP-1:0][ADDR_W-1:0]   cmp_addr,
    output logic                                       hit,
    output logic [WAY_W-1:0]                           hit_way,
    output logic [SLOT_W-1:0]                          hit_slot
);
    logic [NUM_WAYS-1:0][CMP-1:0] eq;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        for (genvar k = 0; k < CMP; k++) begin : g_cmp
            assign eq[w][k] = cmp_vld[w][k] && (cmp_addr[w][k] == key);
        end
    end

    // Walk from the top so the lowest way and its oldest slot are written last
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        hit_slot = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (|eq[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
                for (int k = CMP - 1; k >= 0; k--) begin
                    if (eq[w][k]) hit_slot = SLOT_W'(k);
                end
            end
        end
    end
endmodule

// File: rtl/sb_stream_buffer.sv
module sb_stream_buffer #(
    parameter int NUM_WAYS = 4,
    parameter int DEPTH    = 4,
    parameter int CMP      = 3,
    parameter int ADDR_W   = 28,
    parameter int DATA_W   = 128,
    parameter int GEN_W    = 3,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int TAG_W   = GEN_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [TAG_W-1:0]  mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    import sb_pkg::*;

    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CAND_N = NUM_WAYS * DEPTH;
    localparam int CAND_W = (CAND_N > 1) ? $clog2(CAND_N) : 1;

    typedef struct packed {
        logic              vld;
        logic              iss;
        logic              dvld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef ent_t [NUM_WAYS-1:0][DEPTH-1:0] ent_arr_t;

    typedef struct packed {
        ent_arr_t                         ent;
        logic [NUM_WAYS-1:0]              act;
        logic [NUM_WAYS-1:0][ADDR_W-1:0]  nxt;
        logic [NUM_WAYS-1:0][GEN_W-1:0]   gen;
        sb_mode_e                         mode;
        logic [WAY_W-1:0]                 wway;
        logic                             rvld;
        logic                             rhit;
        logic [DATA_W-1:0]                rdata;
    } st_t;

    st_t      q, d;
    ent_arr_t ent_a;

    // ---------------- prefetch issue selection ----------------
    logic [CAND_N-1:0] cand;
    logic              pick_any;
    logic [CAND_W-1:0] pick_idx;
    logic [WAY_W-1:0]  pick_way;
    logic [SLOT_W-1:0] pick_slot;

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            for (int s = 0; s < DEPTH; s++) begin
                cand[w * DEPTH + s] = q.ent[w][s].vld && !q.ent[w][s].iss;
            end
        end
    end

    sb_pick #(.N(CAND_N), .IDX_W(CAND_W)) u_pick (
        .req (cand),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign pick_way  = WAY_W'(pick_idx / DEPTH);
    assign pick_slot = SLOT_W'(pick_idx % DEPTH);

    assign mem_req_valid = pick_any;
    assign mem_req_addr  = q.ent[pick_way][pick_slot].addr;
    assign mem_req_tag   = {q.gen[pick_way], pick_way};

    // ---------------- response decode ----------------
    logic [WAY_W-1:0] rsp_way;
    logic [GEN_W-1:0] rsp_gen;
    assign rsp_way = mem_rsp_tag[WAY_W-1:0];
    assign rsp_gen = mem_rsp_tag[TAG_W-1:WAY_W];

    // Stage A: mark the issued entry and land returning data
    always_comb begin
        ent_a = q.ent;
        if (pick_any && mem_req_ready) begin
            ent_a[pick_way][pick_slot].iss = 1'b1;
        end
        if (mem_rsp_valid && q.act[rsp_way] && (q.gen[rsp_way] == rsp_gen)) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (ent_a[rsp_way][s].vld && (ent_a[rsp_way][s].addr == mem_rsp_addr)) begin
                    ent_a[rsp_way][s].dvld = 1'b1;
                    ent_a[rsp_way][s].data = mem_rsp_data;
                end
            end
        end
    end

    // ---------------- comparators ----------------
    logic [NUM_WAYS-1:0][CMP-1:0]             cmp_vld;
    logic [NUM_WAYS-1:0][CMP-1:0][ADDR_W-1:0] cmp_addr;
    logic                                     hit;
    logic [WAY_W-1:0]                         hit_way;
    logic [SLOT_W-1:0]                        hit_slot;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp_way
        for (genvar k = 0; k < CMP; k++) begin : g_cmp_slot
            assign cmp_vld[w][k]  = ent_a[w][k].vld;
            assign cmp_addr[w][k] = ent_a[w][k].addr;
        end
    end

    sb_match #(
        .NUM_WAYS (NUM_WAYS),
        .CMP      (CMP),
        .ADDR_W   (ADDR_W),
        .WAY_W    (WAY_W),
        .SLOT_W   (SLOT_W)
    ) u_match (
        .key      (miss_addr),
        .cmp_vld  (cmp_vld),
        .cmp_addr (cmp_addr),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_slot (hit_slot)
    );

    // ---------------- recency ----------------
    logic             lru_touch;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] victim;

    sb_lru #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (lru_touch),
        .touch_way (lru_way),
        .victim    (victim)
    );

    assign miss_ready = (q.mode == SB_IDLE);

    // Stage B: miss handling, pop, reallocation, refill
    int               pop_cnt;
    logic [WAY_W-1:0] pop_way;

    always_comb begin
        d         = q;
        d.ent     = ent_a;
        d.rvld    = 1'b0;
        d.rhit    = 1'b0;
        d.rdata   = '0;
        lru_touch = 1'b0;
        lru_way   = '0;
        pop_cnt   = 0;
        pop_way   = '0;

        if (q.mode == SB_WAIT) begin
            if (ent_a[q.wway][0].dvld) begin
                d.rvld  = 1'b1;
                d.rhit  = 1'b1;
                d.rdata = ent_a[q.wway][0].data;
                pop_way = q.wway;
                pop_cnt = 1;
                d.mode  = SB_IDLE;
            end
        end else if (miss_valid) begin
            if (hit) begin
                lru_touch = 1'b1;
                lru_way   = hit_way;
                pop_way   = hit_way;
                if (ent_a[hit_way][hit_slot].dvld) begin
                    d.rvld  = 1'b1;
                    d.rhit  = 1'b1;
                    d.rdata = ent_a[hit_way][hit_slot].data;
                    pop_cnt = int'(hit_slot) + 1;
                end else begin
                    pop_cnt = int'(hit_slot);
                    d.mode  = SB_WAIT;
                    d.wway  = hit_way;
                end
            end else begin
                lru_touch       = 1'b1;
                lru_way         = victim;
                d.gen[victim]   = q.gen[victim] + 1'b1;
                d.act[victim]   = 1'b1;
                d.nxt[victim]   = miss_addr + 1'b1;
                for (int s = 0; s < DEPTH; s++) d.ent[victim][s] = '0;
                d.rvld          = 1'b1;
                d.rhit          = 1'b0;
            end
        end

        // shift the chosen way forward by pop_cnt entries
        if (pop_cnt != 0) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (s + pop_cnt < DEPTH) d.ent[pop_way][s] = ent_a[pop_way][s + pop_cnt];
                else                     d.ent[pop_way][s] = '0;
            end
        end

        // load every free slot of an active way with the next line address
        for (int w = 0; w < NUM_WAYS; w++) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (d.act[w] && !d.ent[w][s].vld) begin
                    d.ent[w][s].vld  = 1'b1;
                    d.ent[w][s].iss  = 1'b0;
                    d.ent[w][s].dvld = 1'b0;
                    d.ent[w][s].addr = d.nxt[w];
                    d.ent[w][s].data = '0;
                    d.nxt[w]         = d.nxt[w] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign resp_valid = q.rvld;
    assign resp_hit   = q.rhit;
    assign resp_data  = q.rdata;
endmodule

// File: rtl/sb_stream_buffer_chk.sv
module sb_stream_buffer_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [DATA_W-1:0] resp_data,
    input logic              mem_req_valid
);
    AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> (resp_data == '0) && miss_ready);               // R2

    AST_NEW_STREAM_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> mem_req_valid);                                  // R3

    AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(miss_valid && miss_ready) || $past(!miss_ready));      // R8

    AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> resp_valid || !miss_ready);                     // R4

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |-> !resp_valid);                                                // R6

    AST_WAIT_ENDS_IN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_ready) |-> resp_valid && resp_hit);                               // R6
endmodule

bind sb_stream_buffer sb_stream_buffer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_data     (resp_data),
    .mem_req_valid (mem_req_valid)
);

// File: tb/sb_stream_buffer_bench.sv
`timescale 1ns/1ps
module sb_stream_buffer_bench;
    localparam int NW = 4;
    localparam int DP = 4;
    localparam int AW = 28;
    localparam int DW = 128;
    localparam int GW = 3;
    localparam int TW = GW + 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n;
    logic          miss_valid, miss_ready;
    logic [AW-1:0] miss_addr;
    logic          resp_valid, resp_hit;
    logic [DW-1:0] resp_data;
    logic          mem_req_valid, mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic [TW-1:0] mem_req_tag;
    logic          mem_rsp_valid;
    logic [AW-1:0] mem_rsp_addr;
    logic [TW-1:0] mem_rsp_tag;
    logic [DW-1:0] mem_rsp_data;

    sb_stream_buffer u_sb_stream_buffer (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr),
        .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data)
    );

    // ---------------- behavioural reference ----------------
    typedef struct { logic [AW-1:0] a; bit iss; bit dv; } ment_t;
    typedef struct { int due; logic [AW-1:0] a; logic [TW-1:0] tag; } mreq_t;

    ment_t         wq [NW][$];
    bit            act [NW];
    logic [AW-1:0] nxt [NW];
    int            gen [NW];
    int            lru [$];
    bit            waiting;
    int            ww;
    bit            rv, rh;
    logic [DW-1:0] rd;
    mreq_t         mq [$];

    int    cyc = 0, lat = 3, rdy_mode = 0;
    int    errors = 0, checks = 0;
    string ph = "R1 reset";

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return {4'hA, a, 4'h5, ~a, 32'hC0DE0000 ^ {4'h0, a}, {4'h0, a} + 32'd7};
    endfunction

    task automatic check(input string what, input logic [DW-1:0] actual, input logic [DW-1:0] expct);
        checks++;
        if (actual !== expct) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", ph, what, actual, expct);
        end
    endtask

    task automatic touch(input int w);
        foreach (lru[i]) if (lru[i] == w) begin lru.delete(i); break; end
        lru.push_back(w);
    endtask

    task automatic step(input bit mv, input logic [AW-1:0] ma, output bit acc);
        bit fnd; int fw, fs, hw, hs;
        @(negedge clk);
        miss_valid = mv;
        miss_addr  = ma;
        case (rdy_mode)
            0: mem_req_ready = 1'b1;
            1: mem_req_ready = (cyc % 3 != 0);
            default: mem_req_ready = 1'($urandom_range(0, 1));
        endcase
        if (mq.size() > 0 && mq[0].due == cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_addr  = mq[0].a;
            mem_rsp_tag   = mq[0].tag;
            mem_rsp_data  = fdata(mq[0].a);
            void'(mq.pop_front());
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_addr  = '0;
            mem_rsp_tag   = '0;
            mem_rsp_data  = '0;
        end
        #1;
        fnd = 0; fw = 0; fs = 0;
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < wq[w].size(); s++)
                if (!fnd && !wq[w][s].iss) begin fnd = 1; fw = w; fs = s; end
        check("miss_ready", DW'(miss_ready), DW'(!waiting));
        check("resp_valid", DW'(resp_valid), DW'(rv));
        if (rv) begin
            check("resp_hit", DW'(resp_hit), DW'(rh));
            check("resp_data", resp_data, rd);
        end
        check("mem_req_valid", DW'(mem_req_valid), DW'(fnd));
        if (fnd) begin
            check("mem_req_addr", DW'(mem_req_addr), DW'(wq[fw][fs].a));
            check("mem_req_tag", DW'(mem_req_tag), DW'({3'(gen[fw]), 2'(fw)}));
        end
        // advance the reference by one clock
        if (fnd && mem_req_ready) begin
            wq[fw][fs].iss = 1;
            mq.push_back('{cyc + lat, wq[fw][fs].a, {3'(gen[fw]), 2'(fw)}});
        end
        if (mem_rsp_valid) begin
            int rw; rw = int'(mem_rsp_tag[1:0]);
            if (act[rw] && gen[rw] == int'(mem_rsp_tag[4:2]))
                foreach (wq[rw][i]) if (wq[rw][i].a == mem_rsp_addr) wq[rw][i].dv = 1;
        end
        rv = 0; rh = 0; rd = '0; acc = 0;
        if (waiting) begin
            if (wq[ww][0].dv) begin
                rv = 1; rh = 1; rd = fdata(wq[ww][0].a);
                void'(wq[ww].pop_front());
                waiting = 0;
            end
        end else if (mv) begin
            acc = 1; hw = -1; hs = 0;
            for (int w = 0; w < NW; w++)
                for (int s = 0; s < 3 && s < wq[w].size(); s++)
                    if (hw < 0 && wq[w][s].a == ma) begin hw = w; hs = s; end
            if (hw >= 0) begin
                touch(hw);
                repeat (hs) void'(wq[hw].pop_front());
                if (wq[hw][0].dv) begin
                    rv = 1; rh = 1; rd = fdata(wq[hw][0].a);
                    void'(wq[hw].pop_front());
                end else begin
                    waiting = 1; ww = hw;
                end
            end else begin
                int v; v = lru[0];
                touch(v);
                gen[v] = (gen[v] + 1) % 8;
                act[v] = 1;
                wq[v].delete();
                nxt[v] = ma + 1'b1;
                rv = 1; rh = 0; rd = '0;
            end
        end
        for (int w = 0; w < NW; w++)
            while (act[w] && wq[w].size() < DP) begin
                wq[w].push_back('{nxt[w], 0, 0});
                nxt[w] = nxt[w] + 1'b1;
            end
        cyc++;
    endtask

    task automatic do_miss(input logic [AW-1:0] a);
        bit acc;
        do step(1'b1, a, acc); while (!acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        repeat (n) step(1'b0, '0, acc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) begin act[w] = 0; gen[w] = 0; nxt[w] = '0; end
        lru = '{0, 1, 2, 3};
        waiting = 0; ww = 0; rv = 0; rh = 0; rd = '0;
        rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0; mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0; mem_rsp_addr = '0; mem_rsp_tag = '0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        #1;
        check("miss_ready in reset", DW'(miss_ready), DW'(1));    // R1
        check("resp_valid in reset", DW'(resp_valid), DW'(0));
        check("mem_req_valid in reset", DW'(mem_req_valid), DW'(0));
        rst_n = 1'b1;
        idle(2);

        ph = "R2 R3 new stream";        do_miss(28'd100); idle(10);
        ph = "R4 head hit";             do_miss(28'd101); idle(4);
        ph = "R5 skip one";             do_miss(28'd103); idle(4);
        ph = "R5 fourth entry";         do_miss(28'd107); idle(10);
        ph = "R10 lowest way";          do_miss(28'd103); idle(8); do_miss(28'd105); idle(10);
        ph = "R6 pending"; lat = 8;     do_miss(28'd500); do_miss(28'd501); do_miss(28'd502); idle(20);
        ph = "R7 R8 streams"; lat = 3;
        do_miss(28'd1000); do_miss(28'd2000); do_miss(28'd3000); do_miss(28'd4000); idle(10);
        do_miss(28'd1001); do_miss(28'd2001); do_miss(28'd3001); do_miss(28'd4001);
        do_miss(28'd1002); do_miss(28'd5000); idle(10);
        ph = "R9 stale"; lat = 10;
        do_miss(28'd9000); do_miss(28'd9100); do_miss(28'd9200); do_miss(28'd9300);
        do_miss(28'd9000); do_miss(28'd9001); idle(25);
        ph = "R11 throttled"; lat = 2; rdy_mode = 1;
        do_miss(28'd7000); do_miss(28'd7001); do_miss(28'd7003); do_miss(28'd8000); idle(20);
        ph = "R11 random"; lat = 4; rdy_mode = 2;
        for (int i = 0; i < 400; i++) begin
            do_miss(28'(64 * $urandom_range(0, 5) + $urandom_range(0, 10)));
            idle($urandom_range(0, 2));
        end
        idle(20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule